// File: doc/BRIEF.md
# Processor Cell Insert/Extract Buffer Pair

This block gives a microprocessor a path into and out of a transmit ATM cell stream. The insertion buffer collects bytes that the processor writes one at a time and offers them to the transmit path only as complete 53-byte cells. The extraction buffer works the other way round. It accepts whole cells from the transmit path and lets the processor read them back a byte at a time.

Both buffers hold four cells. They track occupancy in complete cells only, so a half-written or half-read cell never changes a status flag. An 8-bit control/status register carries the following:
- an enable bit for each buffer, where clearing the bit from 1 to 0 flushes that buffer;
- a cell-available flag for the extraction buffer;
- a room flag for the insertion buffer;
- a write-only start-of-cell strobe for the insertion buffer.

Top module: `atm_cell_bridge`

## Requirements
- R1: The register reads as {3'b000, ext_en, avail, ins_en, room, 1'b0}. Bit 0 always reads 0. Bits 4 and 2 read back the last value written and are 1 after reset.
- R2: The insertion buffer raises tx_ins_cell_rdy only after the 53rd byte of a cell has been written. A partly written cell does not count.
- R3: Each tx_ins_rd pulse while tx_ins_cell_rdy is high moves the buffer on by one byte, and bytes come out in write order. tx_ins_sop is high on byte 0 of a cell. A pull while no complete cell is stored has no effect.
- R4: The room flag (bit 1) is 1 when the insertion buffer is enabled and holds fewer than 4 complete cells. Otherwise it is 0.
- R5: A cell whose first byte is written while 4 complete cells are stored is discarded whole.
- R6: Writing 1 to bit 0 makes the next processor data write byte 0 of a cell. This also applies when a cell is part-written, and the partial bytes are then discarded. After a cell completes, the next data write starts a new cell with no strobe needed.
- R7: The available flag (bit 3) is 1 when at least one complete cell is in the extraction buffer. It stays 1 during a partial processor read and clears after the last byte of the last cell is read. Bytes are read in arrival order.
- R8: The extraction buffer discards an incoming cell that begins while 4 cells are stored.
- R9: Writing 0 to an enable bit that holds 1 empties that buffer and resets its pointers in the same cycle.
- R10: While an enable bit is 0, that buffer ignores all writes and reads. After 1 is written back, the buffer works again starting from empty.
- R11: Writing 1 to an enable bit that already holds 1 leaves the stored cells untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_reg_wr | input | 1 | Control register write strobe |
| cpu_reg_wdata | input | 8 | Control register write data |
| cpu_reg_rdata | output | 8 | Control/status register read value |
| cpu_ins_wr | input | 1 | Processor byte write into insertion buffer |
| cpu_ins_data | input | 8 | Byte written into insertion buffer |
| cpu_ext_rd | input | 1 | Processor byte read from extraction buffer |
| cpu_ext_data | output | 8 | Current extraction byte (valid while avail is 1) |
| tx_ins_rd | input | 1 | Transmit path pulls one insertion byte |
| tx_ins_data | output | 8 | Current insertion byte for transmit path |
| tx_ins_sop | output | 1 | Current insertion byte is byte 0 of a cell |
| tx_ins_cell_rdy | output | 1 | At least one complete cell is ready for transmit |
| tx_ext_wr | input | 1 | Transmit path writes one byte into extraction buffer |
| tx_ext_sop | input | 1 | Byte written is byte 0 of a cell |
| tx_ext_data | input | 8 | Byte written into extraction buffer |

## Verification
A corrupted cell count or pointer shows at the ports within one cell time. The flags change at the wrong byte, or the first byte pulled after a cell boundary carries another cell's tag. Every byte pattern therefore encodes its cell number and byte index, and the bench compares every byte read. A flush that fails to reset pointers shows on the first byte read after re-enable. A flag that moves on a partial cell shows one cycle after the 52nd byte.

// File: rtl/atm_cbuf_pkg.sv
package atm_cbuf_pkg;
   localparam int CR_SOC    = 0;
   localparam int CR_ROOM   = 1;
   localparam int CR_INS_EN = 2;
   localparam int CR_AVAIL  = 3;
   localparam int CR_EXT_EN = 4;

   typedef struct packed {
      logic ext_en;
      logic ins_en;
      logic soc_pend;
   } cbuf_ctrl_t;
endpackage

// File: rtl/cell_fifo.sv
module cell_fifo #(
   parameter int DW         = 8,
   parameter int CELL_BYTES = 53,
   parameter int CELLS      = 4,
   localparam int CW = (CELLS > 1) ? $clog2(CELLS) : 1,
   localparam int NW = $clog2(CELLS + 1),
   localparam int BW = $clog2(CELL_BYTES),
   localparam int AW = $clog2(CELLS * CELL_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          flush,
   input  logic          wr_en,
   input  logic          wr_sop,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          rd_sop,
   output logic [NW-1:0] cell_cnt
);
   localparam int DEPTH = CELLS * CELL_BYTES;
   localparam logic [BW-1:0] LAST_BYTE = BW'(CELL_BYTES - 1);

   if (CELL_BYTES < 2) begin : g_bad_cell
      $error("cell_fifo: CELL_BYTES must be at least 2");
   end
   if (CELLS < 1) begin : g_bad_depth
      $error("cell_fifo: CELLS must be at least 1");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [CW-1:0] wr_cell, rd_cell, wr_cell_nxt, rd_cell_nxt;
   logic [BW-1:0] wr_byte, rd_byte, cur_idx;
   logic          wr_drop, drop_now, wr_go, rd_go, commit, release_c;
   logic [AW-1:0] wr_addr, rd_addr;

   if ((1 << CW) == CELLS) begin : g_wrap_pow2
      assign wr_cell_nxt = wr_cell + 1'b1;
      assign rd_cell_nxt = rd_cell + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_cell_nxt = (wr_cell == CW'(CELLS - 1)) ? '0 : wr_cell + 1'b1;
      assign rd_cell_nxt = (rd_cell == CW'(CELLS - 1)) ? '0 : rd_cell + 1'b1;
   end

   assign cur_idx   = wr_sop ? '0 : wr_byte;
   assign drop_now  = (cur_idx == '0) ? (cell_cnt == NW'(CELLS)) : wr_drop;
   assign wr_go     = enable && wr_en;
   assign rd_go     = enable && rd_en && (cell_cnt != '0);
   assign commit    = wr_go && !drop_now && (cur_idx == LAST_BYTE);
   assign release_c = rd_go && (rd_byte == LAST_BYTE);
   assign wr_addr   = AW'(wr_cell) * AW'(CELL_BYTES) + AW'(cur_idx);
   assign rd_addr   = AW'(rd_cell) * AW'(CELL_BYTES) + AW'(rd_byte);
   assign rd_data   = mem[rd_addr];
   assign rd_sop    = (cell_cnt != '0) && (rd_byte == '0);

   always_ff @(posedge clk) begin
      if (wr_go && !drop_now) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_cell  <= '0;
         rd_cell  <= '0;
         wr_byte  <= '0;
         rd_byte  <= '0;
         wr_drop  <= 1'b0;
         cell_cnt <= '0;
      end else if (flush) begin
         wr_cell  <= '0;
         rd_cell  <= '0;
         wr_byte  <= '0;
         rd_byte  <= '0;
         wr_drop  <= 1'b0;
         cell_cnt <= '0;
      end else begin
         if (wr_go) begin
            wr_drop <= drop_now;
            if (cur_idx == LAST_BYTE) begin
               wr_byte <= '0;
               if (!drop_now) wr_cell <= wr_cell_nxt;
            end else begin
               wr_byte <= cur_idx + 1'b1;
            end
         end
         if (rd_go) begin
            if (rd_byte == LAST_BYTE) begin
               rd_byte <= '0;
               rd_cell <= rd_cell_nxt;
            end else begin
               rd_byte <= rd_byte + 1'b1;
            end
         end
         if (commit && !release_c)      cell_cnt <= cell_cnt + 1'b1;
         else if (release_c && !commit) cell_cnt <= cell_cnt - 1'b1;
      end
   end
endmodule

// File: rtl/cbuf_ctrl_reg.sv
module cbuf_ctrl_reg
   import atm_cbuf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [7:0] wdata,
   input  logic       ins_wr,
   input  logic       avail,
   input  logic       room,
   output logic [7:0] rdata,
   output cbuf_ctrl_t ctrl,
   output logic       flush_ins,
   output logic       flush_ext
);
   assign flush_ins = reg_wr && ctrl.ins_en && !wdata[CR_INS_EN];
   assign flush_ext = reg_wr && ctrl.ext_en && !wdata[CR_EXT_EN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl.ext_en   <= 1'b1;
         ctrl.ins_en   <= 1'b1;
         ctrl.soc_pend <= 1'b0;
      end else begin
         if (reg_wr) begin
            ctrl.ext_en <= wdata[CR_EXT_EN];
            ctrl.ins_en <= wdata[CR_INS_EN];
         end
         if (flush_ins || ins_wr)          ctrl.soc_pend <= 1'b0;
         else if (reg_wr && wdata[CR_SOC]) ctrl.soc_pend <= 1'b1;
      end
   end

   always_comb begin
      rdata            = '0;
      rdata[CR_EXT_EN] = ctrl.ext_en;
      rdata[CR_AVAIL]  = avail;
      rdata[CR_INS_EN] = ctrl.ins_en;
      rdata[CR_ROOM]   = room;
   end
endmodule

// File: rtl/atm_cell_bridge.sv
module atm_cell_bridge
   import atm_cbuf_pkg::*;
#(
   parameter int CELL_BYTES = 53,
   parameter int CELLS      = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cpu_reg_wr,
   input  logic [7:0] cpu_reg_wdata,
   output logic [7:0] cpu_reg_rdata,
   input  logic       cpu_ins_wr,
   input  logic [7:0] cpu_ins_data,
   input  logic       cpu_ext_rd,
   output logic [7:0] cpu_ext_data,
   input  logic       tx_ins_rd,
   output logic [7:0] tx_ins_data,
   output logic       tx_ins_sop,
   output logic       tx_ins_cell_rdy,
   input  logic       tx_ext_wr,
   input  logic       tx_ext_sop,
   input  logic [7:0] tx_ext_data
);
   localparam int NW = $clog2(CELLS + 1);

   cbuf_ctrl_t    ctrl;
   logic          flush_ins, flush_ext, room, avail, ext_sop_unused;
   logic [NW-1:0] ins_cnt, ext_cnt;

   assign room            = ctrl.ins_en && (ins_cnt < NW'(CELLS));
   assign avail           = ctrl.ext_en && (ext_cnt != '0);
   assign tx_ins_cell_rdy = ctrl.ins_en && (ins_cnt != '0);

   cbuf_ctrl_reg u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (cpu_reg_wr),
      .wdata     (cpu_reg_wdata),
      .ins_wr    (cpu_ins_wr),
      .avail     (avail),
      .room      (room),
      .rdata     (cpu_reg_rdata),
      .ctrl      (ctrl),
      .flush_ins (flush_ins),
      .flush_ext (flush_ext)
   );

   cell_fifo #(.DW(8), .CELL_BYTES(CELL_BYTES), .CELLS(CELLS)) u_ins (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (ctrl.ins_en),
      .flush    (flush_ins),
      .wr_en    (cpu_ins_wr),
      .wr_sop   (ctrl.soc_pend),
      .wr_data  (cpu_ins_data),
      .rd_en    (tx_ins_rd),
      .rd_data  (tx_ins_data),
      .rd_sop   (tx_ins_sop),
      .cell_cnt (ins_cnt)
   );

   cell_fifo #(.DW(8), .CELL_BYTES(CELL_BYTES), .CELLS(CELLS)) u_ext (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (ctrl.ext_en),
      .flush    (flush_ext),
      .wr_en    (tx_ext_wr),
      .wr_sop   (tx_ext_sop),
      .wr_data  (tx_ext_data),
      .rd_en    (cpu_ext_rd),
      .rd_data  (cpu_ext_data),
      .rd_sop   (ext_sop_unused),
      .cell_cnt (ext_cnt)
   );
endmodule

// File: rtl/atm_cell_bridge_chk.sv
module atm_cell_bridge_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_reg_wr,
   input logic [7:0] cpu_reg_wdata,
   input logic [7:0] cpu_reg_rdata,
   input logic       cpu_ext_rd,
   input logic       tx_ins_cell_rdy
);
   p_fixed_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_reg_rdata[7:5] == 3'b000 && cpu_reg_rdata[0] == 1'b0);

   p_full_means_rdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_reg_rdata[2] && !cpu_reg_rdata[1]) |-> tx_ins_cell_rdy);

   p_avail_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_reg_rdata[3] && !cpu_ext_rd && !cpu_reg_wr) |=> cpu_reg_rdata[3]);

   p_ext_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_reg_wr && cpu_reg_rdata[4] && !cpu_reg_wdata[4]) |=> !cpu_reg_rdata[3]);

   p_ins_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_reg_wr && cpu_reg_rdata[2] && !cpu_reg_wdata[2]) |=> !tx_ins_cell_rdy);

   p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_reg_rdata[2] |-> (!cpu_reg_rdata[1] && !tx_ins_cell_rdy));
endmodule

bind atm_cell_bridge atm_cell_bridge_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .cpu_reg_wr      (cpu_reg_wr),
   .cpu_reg_wdata   (cpu_reg_wdata),
   .cpu_reg_rdata   (cpu_reg_rdata),
   .cpu_ext_rd      (cpu_ext_rd),
   .tx_ins_cell_rdy (tx_ins_cell_rdy)
);

// File: tb/atm_cell_bridge_tb.sv
module atm_cell_bridge_tb;
   localparam int CB = 53;
   localparam int NV = 5;
   localparam logic [15:0] VEC [NV] = '{16'hFF16, 16'h1010, 16'h0000, 16'h0406, 16'h1416};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_reg_wr = 1'b0, cpu_ins_wr = 1'b0, cpu_ext_rd = 1'b0;
   logic       tx_ins_rd = 1'b0, tx_ext_wr = 1'b0, tx_ext_sop = 1'b0;
   logic [7:0] cpu_reg_wdata = '0, cpu_ins_data = '0, tx_ext_data = '0;
   logic [7:0] cpu_reg_rdata, cpu_ext_data, tx_ins_data;
   logic       tx_ins_sop, tx_ins_cell_rdy;
   int         n_cmp = 0, n_bad = 0;

   always #10 clk = ~clk;

   atm_cell_bridge u_dut (.*);

   function automatic logic [7:0] pat(int c, int i);
      return 8'(c * 7 + i * 3 + 1);
   endfunction

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [7:0] v);
      cpu_reg_wr = 1'b1; cpu_reg_wdata = v;
      @(negedge clk);
      cpu_reg_wr = 1'b0;
   endtask

   task automatic ins_bytes(input int c, input int from, input int upto);
      for (int i = from; i < upto; i++) begin
         cpu_ins_wr = 1'b1; cpu_ins_data = pat(c, i);
         @(negedge clk);
         cpu_ins_wr = 1'b0;
      end
   endtask

   task automatic ext_cell(input int c);
      for (int i = 0; i < CB; i++) begin
         tx_ext_wr = 1'b1; tx_ext_sop = (i == 0); tx_ext_data = pat(c, i);
         @(negedge clk);
         tx_ext_wr = 1'b0; tx_ext_sop = 1'b0;
      end
   endtask

   task automatic pull_cell(input int c, input string tag);
      for (int i = 0; i < CB; i++) begin
         chk({8'h0, tx_ins_data}, {8'h0, pat(c, i)}, tag);
         if (i == 0) chk({15'h0, tx_ins_sop}, 16'h1, {tag, " sop"});
         tx_ins_rd = 1'b1;
         @(negedge clk);
         tx_ins_rd = 1'b0;
      end
   endtask

   task automatic read_bytes(input int c, input int from, input int upto, input string tag);
      for (int i = from; i < upto; i++) begin
         chk({8'h0, cpu_ext_data}, {8'h0, pat(c, i)}, tag);
         cpu_ext_rd = 1'b1;
         @(negedge clk);
         cpu_ext_rd = 1'b0;
      end
   endtask

   task automatic run_tests();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({8'h0, cpu_reg_rdata}, 16'h0016, "R1 reset value");
      chk({15'h0, tx_ins_cell_rdy}, 16'h0, "R2 reset no cell");

      foreach (VEC[k]) begin
         reg_wr(VEC[k][15:8]);
         chk({8'h0, cpu_reg_rdata}, {8'h0, VEC[k][7:0]}, "R1 R9 R10 register vector");
      end

      reg_wr(8'h15);
      ins_bytes(1, 0, CB - 1);
      chk({15'h0, tx_ins_cell_rdy}, 16'h0, "R2 partial cell hidden");
      ins_bytes(1, CB - 1, CB);
      chk({15'h0, tx_ins_cell_rdy}, 16'h1, "R2 complete cell ready");
      pull_cell(1, "R3 byte order");
      chk({15'h0, tx_ins_cell_rdy}, 16'h0, "R3 drained");
      tx_ins_rd = 1'b1; @(negedge clk); tx_ins_rd = 1'b0;
      ins_bytes(2, 0, CB);
      pull_cell(2, "R3 empty pull ignored");

      for (int c = 0; c < 4; c++) begin
         chk({15'h0, cpu_reg_rdata[1]}, 16'h1, "R4 room while below four");
         reg_wr(8'h15);
         ins_bytes(10 + c, 0, CB);
      end
      chk({15'h0, cpu_reg_rdata[1]}, 16'h0, "R4 room clear when full");
      reg_wr(8'h15);
      ins_bytes(20, 0, CB);
      for (int c = 0; c < 4; c++) pull_cell(10 + c, "R5 stored cells intact");
      chk({15'h0, tx_ins_cell_rdy}, 16'h0, "R5 fifth cell discarded");

      reg_wr(8'h15);
      ins_bytes(30, 0, 20);
      reg_wr(8'h15);
      ins_bytes(31, 0, CB);
      ins_bytes(32, 0, CB);
      pull_cell(31, "R6 realigned cell");
      pull_cell(32, "R6 unstrobed next cell");
      chk({15'h0, tx_ins_cell_rdy}, 16'h0, "R6 partial discarded");

      ext_cell(40);
      chk({15'h0, cpu_reg_rdata[3]}, 16'h1, "R7 avail set");
      read_bytes(40, 0, CB - 1, "R7 read order");
      chk({15'h0, cpu_reg_rdata[3]}, 16'h1, "R7 avail held on partial read");
      read_bytes(40, CB - 1, CB, "R7 last byte");
      chk({15'h0, cpu_reg_rdata[3]}, 16'h0, "R7 avail clear");

      for (int c = 0; c < 5; c++) ext_cell(50 + c);
      for (int c = 0; c < 4; c++) read_bytes(50 + c, 0, CB, "R8 stored cells");
      chk({15'h0, cpu_reg_rdata[3]}, 16'h0, "R8 fifth cell dropped");

      ext_cell(60);
      ext_cell(61);
      ins_bytes(62, 0, CB);
      reg_wr(8'h14);
      chk({15'h0, cpu_reg_rdata[3]}, 16'h1, "R11 ext kept");
      chk({15'h0, tx_ins_cell_rdy}, 16'h1, "R11 ins kept");
      read_bytes(60, 0, 3, "R11 data kept");
      reg_wr(8'h04);
      chk({8'h0, cpu_reg_rdata}, 16'h0006, "R9 ext flushed");
      ext_cell(63);
      reg_wr(8'h14);
      chk({15'h0, cpu_reg_rdata[3]}, 16'h0, "R10 ext ignored while off");
      ext_cell(64);
      read_bytes(64, 0, 2, "R10 ext restart from empty");
      reg_wr(8'h10);
      chk({15'h0, tx_ins_cell_rdy}, 16'h0, "R9 ins flushed");
      ins_bytes(65, 0, CB);
      reg_wr(8'h15);
      chk({15'h0, tx_ins_cell_rdy}, 16'h0, "R10 ins ignored while off");
      chk({15'h0, cpu_reg_rdata[1]}, 16'h1, "R10 room after enable");
      ins_bytes(66, 0, CB);
      pull_cell(66, "R10 ins restart from empty");
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (100000) @(posedge clk);
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule